// File: doc/BRIEF.md
# SPI Master Transfer Delay Sequencer

This block times a single serial transfer of an SPI master. When enabled and offered a queued entry, it drives chip select active low, waits a lead delay, generates a fixed number of serial clock pulses, raises chip select with the last falling clock edge, and then stays busy through a trailing delay before it can accept the next entry. Each entry carries two selector bits. One picks the programmed lead delay or half a serial clock period. The other picks the programmed trailing delay or a fixed 17-clock default. A simple bit counter stands in for the shift register.

The enable is a register that software sets and clears with pulses. Clearing it stops the block on the next clock edge, even partway through a transfer. A mode fault also clears it and sets a sticky flag. The fault occurs when the block is master, the slave-select pin is configured as an input, and that pin is pulled low. An orderly stop uses the halt request. The current transfer, including its trailing delay, runs to its end, and then the halt acknowledge rises. No new transfer starts while the request stays high.

States: IDLE (waits for an entry), LEAD (chip select low, lead delay running), SHIFT (serial clock toggling), TRAIL (chip select high, trailing delay running), HALTED (acknowledge high). Transitions: IDLE→LEAD on an entry with no halt request; IDLE→HALTED on a halt request; LEAD→SHIFT when the lead counter reaches zero; SHIFT→TRAIL on the last falling clock edge; TRAIL→IDLE when the trail counter reaches zero and there is no halt request, or TRAIL→HALTED when there is; HALTED→IDLE when the request drops. Any state goes to IDLE when the enable clears.

Top module: `spi_xfer_timer`

## Requirements
- R1: With entry_pre_sel_i=1 and pre_dly_i from 2 to 127, sck_o first rises exactly pre_dly_i clocks after cs_n_o falls.
- R2: With entry_pre_sel_i=1, pre_dly_i=0 gives a lead of 128 clocks and pre_dly_i=1 gives a lead of 2 clocks.
- R3: With entry_pre_sel_i=0, pre_dly_i has no effect and the lead is half_period_i clocks (a value of 0 acts as 1).
- R4: sck_o idles low and gives BITS (default 8) high pulses per transfer, each high for H clocks and separated by H low clocks, where H is half_period_i. cs_n_o rises on the same edge as the last falling edge of sck_o, and sck_o is never high while cs_n_o is high.
- R5: With entry_post_sel_i=1, busy_o stays high for 32*post_dly_i clocks after cs_n_o rises, and post_dly_i=0 gives 8192 clocks.
- R6: With entry_post_sel_i=0, busy_o stays high for 17 clocks after cs_n_o rises, whatever post_dly_i holds.
- R7: entry_take_o is high in exactly the cycle before cs_n_o falls to start a transfer, and only when spe_o stays set.
- R8: A halt request raised during a transfer lets it finish, including its trailing delay. halt_ack_o then rises in the cycle busy_o falls, and no transfer starts while halt_req_i is high. After the request drops, halt_ack_o falls one clock later and a pending entry starts the clock after that.
- R9: A spe_clr_i pulse makes spe_o, busy_o and sck_o low and cs_n_o high at the next edge, even mid-transfer. No entry is taken while spe_o is low.
- R10: When ss_is_input_i=1, master_i=1 and ss_n_i=0, spe_o clears and modf_o sets at the next edge. modf_o stays set until reset. Without all three conditions, no fault occurs.
- R11: After reset, cs_n_o=1 and sck_o, busy_o, halt_ack_o, spe_o, modf_o and entry_take_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spe_set_i | input | 1 | Pulse that sets the enable |
| spe_clr_i | input | 1 | Pulse that clears the enable (immediate stop) |
| halt_req_i | input | 1 | Orderly halt request (level) |
| entry_valid_i | input | 1 | A queue entry is ready to transfer |
| entry_pre_sel_i | input | 1 | Entry bit: 1 selects the programmed lead delay, 0 selects half a period |
| entry_post_sel_i | input | 1 | Entry bit: 1 selects the programmed trailing delay, 0 selects 17 clocks |
| pre_dly_i | input | PRE_W (7) | Programmed lead delay in clocks |
| post_dly_i | input | POST_W (8) | Programmed trailing delay in units of 32 clocks |
| half_period_i | input | HALF_W (8) | Half of the serial clock period in clocks |
| ss_is_input_i | input | 1 | Slave-select pin is configured as an input |
| master_i | input | 1 | Block operates as master |
| ss_n_i | input | 1 | Level on the slave-select pin |
| cs_n_o | output | 1 | Peripheral chip select, active low |
| sck_o | output | 1 | Serial clock |
| busy_o | output | 1 | Transfer or trailing delay in progress |
| entry_take_o | output | 1 | Entry accepted this cycle |
| halt_ack_o | output | 1 | Halt acknowledge |
| spe_o | output | 1 | Enable state |
| modf_o | output | 1 | Sticky mode fault flag |

## Verification
The bench goes after the encoding corners of both delay fields: a lead value of 0 must give 128 clocks, not 0 or 127, and a value of 1 must give 2, not 1. A trailing value of 0 must give 8192 clocks, not a zero-length wait. A design with an off-by-one in its counter reload would show every measured lead and trail one clock too long or too short. The bench also checks that a deselected field is truly ignored, that a halt waits for the trailing delay rather than cutting it short, and that clearing the enable mid-shift drops chip select at once instead of finishing the byte. Finally, it checks that a fault is flagged only when all three pin conditions hold and that the flag outlives re-enabling.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_SHIFT  = 3'd2,
        ST_TRAIL  = 3'd3,
        ST_HALTED = 3'd4
    } xfer_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/spi_enable_ctl.sv
module spi_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic spe_set_i,
    input  logic spe_clr_i,
    input  logic ss_is_input_i,
    input  logic master_i,
    input  logic ss_n_i,
    output logic spe_q_o,
    output logic spe_next_o,
    output logic modf_o
);
    logic fault;
    logic modf_q;

    assign fault = ss_is_input_i & master_i & ~ss_n_i;

    // fault has priority over clear, clear over set
    always_comb begin
        if (fault)          spe_next_o = 1'b0;
        else if (spe_clr_i) spe_next_o = 1'b0;
        else if (spe_set_i) spe_next_o = 1'b1;
        else                spe_next_o = spe_q_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spe_q_o <= 1'b0;
            modf_q  <= 1'b0;
        end else begin
            spe_q_o <= spe_next_o;
            if (fault) modf_q <= 1'b1;
        end
    end

    assign modf_o = modf_q;
endmodule

// File: rtl/spi_delay_sel.sv
module spi_delay_sel #(
    parameter int PRE_W      = 7,
    parameter int POST_W     = 8,
    parameter int HALF_W     = 8,
    parameter int CNT_W      = 14,
    parameter int TRAIL_MULT = 32,
    parameter int STD_TRAIL  = 17
) (
    input  logic              pre_sel_i,
    input  logic [PRE_W-1:0]  pre_dly_i,
    input  logic              post_sel_i,
    input  logic [POST_W-1:0] post_dly_i,
    input  logic [HALF_W-1:0] half_period_i,
    output logic [CNT_W-1:0]  lead_o,
    output logic [CNT_W-1:0]  trail_o,
    output logic [CNT_W-1:0]  half_o
);
    localparam int PRE_WRAP  = 2 ** PRE_W;
    localparam int POST_WRAP = 2 ** POST_W;

    logic [CNT_W-1:0] post_units;

    always_comb begin
        if (half_period_i == '0) half_o = CNT_W'(1);
        else                     half_o = CNT_W'(half_period_i);
    end

    always_comb begin
        if (!pre_sel_i)                     lead_o = half_o;
        else if (pre_dly_i == '0)           lead_o = CNT_W'(PRE_WRAP);
        else if (pre_dly_i == PRE_W'(1))    lead_o = CNT_W'(2);
        else                                lead_o = CNT_W'(pre_dly_i);
    end

    always_comb begin
        if (post_dly_i == '0) post_units = CNT_W'(POST_WRAP);
        else                  post_units = CNT_W'(post_dly_i);
        if (post_sel_i) trail_o = post_units * CNT_W'(TRAIL_MULT);
        else            trail_o = CNT_W'(STD_TRAIL);
    end
endmodule

// File: rtl/spi_phase_fsm.sv
module spi_phase_fsm
    import spi_xfer_pkg::*;
#(
    parameter int BITS  = 8,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spe_next_i,
    input  logic             entry_valid_i,
    input  logic             halt_req_i,
    input  logic [CNT_W-1:0] lead_i,
    input  logic [CNT_W-1:0] trail_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             busy_o,
    output logic             halt_ack_o,
    output logic             entry_take_o
);
    localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    xfer_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             sck_q;

    // state register with its phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b0;
        end else if (!spe_next_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (halt_req_i) begin
                        state_q <= ST_HALTED;
                    end else if (entry_valid_i) begin
                        state_q <= ST_LEAD;
                        cnt_q   <= lead_i - CNT_W'(1);
                    end
                end
                ST_LEAD: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_SHIFT;
                        sck_q   <= 1'b1;
                        bit_q   <= '0;
                        cnt_q   <= half_i - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (sck_q) begin
                        sck_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                            state_q <= ST_TRAIL;
                            cnt_q   <= trail_i - CNT_W'(1);
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                            cnt_q <= half_i - CNT_W'(1);
                        end
                    end else begin
                        sck_q <= 1'b1;
                        cnt_q <= half_i - CNT_W'(1);
                    end
                end
                ST_TRAIL: begin
                    if (cnt_q == '0) begin
                        state_q <= halt_req_i ? ST_HALTED : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_HALTED: begin
                    if (!halt_req_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_n_o       = 1'b1;
        busy_o       = 1'b0;
        halt_ack_o   = 1'b0;
        entry_take_o = 1'b0;
        sck_o        = sck_q;
        unique case (state_q)
            ST_IDLE:   entry_take_o = spe_next_i & entry_valid_i & ~halt_req_i;
            ST_LEAD:   begin cs_n_o = 1'b0; busy_o = 1'b1; end
            ST_SHIFT:  begin cs_n_o = 1'b0; busy_o = 1'b1; end
            ST_TRAIL:  busy_o = 1'b1;
            ST_HALTED: halt_ack_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/spi_xfer_timer.sv
module spi_xfer_timer
    import spi_xfer_pkg::*;
#(
    parameter int BITS       = 8,
    parameter int PRE_W      = 7,
    parameter int POST_W     = 8,
    parameter int HALF_W     = 8,
    parameter int TRAIL_MULT = 32,
    parameter int STD_TRAIL  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spe_set_i,
    input  logic              spe_clr_i,
    input  logic              halt_req_i,
    input  logic              entry_valid_i,
    input  logic              entry_pre_sel_i,
    input  logic              entry_post_sel_i,
    input  logic [PRE_W-1:0]  pre_dly_i,
    input  logic [POST_W-1:0] post_dly_i,
    input  logic [HALF_W-1:0] half_period_i,
    input  logic              ss_is_input_i,
    input  logic              master_i,
    input  logic              ss_n_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              busy_o,
    output logic              entry_take_o,
    output logic              halt_ack_o,
    output logic              spe_o,
    output logic              modf_o
);
    localparam int MAX_TRAIL = TRAIL_MULT * (2 ** POST_W);
    localparam int MAX_CNT   = max2(max2(MAX_TRAIL, STD_TRAIL),
                                    max2(2 ** PRE_W, 2 ** HALF_W));
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    logic             spe_next;
    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] trail_len;
    logic [CNT_W-1:0] half_len;

    spi_enable_ctl u_enable (
        .clk           (clk),
        .rst_n         (rst_n),
        .spe_set_i     (spe_set_i),
        .spe_clr_i     (spe_clr_i),
        .ss_is_input_i (ss_is_input_i),
        .master_i      (master_i),
        .ss_n_i        (ss_n_i),
        .spe_q_o       (spe_o),
        .spe_next_o    (spe_next),
        .modf_o        (modf_o)
    );

    spi_delay_sel #(
        .PRE_W      (PRE_W),
        .POST_W     (POST_W),
        .HALF_W     (HALF_W),
        .CNT_W      (CNT_W),
        .TRAIL_MULT (TRAIL_MULT),
        .STD_TRAIL  (STD_TRAIL)
    ) u_delays (
        .pre_sel_i     (entry_pre_sel_i),
        .pre_dly_i     (pre_dly_i),
        .post_sel_i    (entry_post_sel_i),
        .post_dly_i    (post_dly_i),
        .half_period_i (half_period_i),
        .lead_o        (lead_len),
        .trail_o       (trail_len),
        .half_o        (half_len)
    );

    spi_phase_fsm #(
        .BITS  (BITS),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .spe_next_i    (spe_next),
        .entry_valid_i (entry_valid_i),
        .halt_req_i    (halt_req_i),
        .lead_i        (lead_len),
        .trail_i       (trail_len),
        .half_i        (half_len),
        .cs_n_o        (cs_n_o),
        .sck_o         (sck_o),
        .busy_o        (busy_o),
        .halt_ack_o    (halt_ack_o),
        .entry_take_o  (entry_take_o)
    );
endmodule

// File: rtl/spi_xfer_timer_chk.sv
module spi_xfer_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic spe_clr_i,
    input logic ss_is_input_i,
    input logic master_i,
    input logic ss_n_i,
    input logic cs_n_o,
    input logic sck_o,
    input logic busy_o,
    input logic entry_take_o,
    input logic halt_ack_o,
    input logic spe_o,
    input logic modf_o
);
    a_r4_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    a_r7_take_starts_cs: assert property (@(posedge clk) disable iff (!rst_n)
        entry_take_o |=> !cs_n_o);

    a_r8_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ack_o |-> (cs_n_o && !busy_o && !entry_take_o));

    a_r9_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        spe_clr_i |=> (!spe_o && cs_n_o && !sck_o && !busy_o));

    a_r9_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!spe_o && !spe_clr_i) |=> (!busy_o || spe_o || $past(spe_o)));

    a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_is_input_i && master_i && !ss_n_i) |=> (!spe_o && modf_o));

    a_r10_modf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        modf_o |=> modf_o);
endmodule

bind spi_xfer_timer spi_xfer_timer_chk chk_i (.*);

// File: tb/spi_xfer_timer_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spe_set_i = 0, spe_clr_i = 0, halt_req_i = 0, entry_valid_i = 0;
    logic       entry_pre_sel_i = 0, entry_post_sel_i = 0;
    logic [6:0] pre_dly_i = 0;
    logic [7:0] post_dly_i = 0;
    logic [7:0] half_period_i = 1;
    logic       ss_is_input_i = 0, master_i = 1, ss_n_i = 1;
    logic       cs_n_o, sck_o, busy_o, entry_take_o, halt_ack_o, spe_o, modf_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spi_xfer_timer dut_i (.*);

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    task automatic pulse_set();
        spe_set_i = 1;
        @(negedge clk);
        spe_set_i = 0;
    endtask

    // one complete transfer, measured at the ports
    task automatic run_xfer(input bit ps, input logic [6:0] pd, input bit qs,
                            input logic [7:0] qd, input logic [7:0] h,
                            input int exp_lead, input int exp_high, input int exp_trail,
                            input string lead_tag, input string trail_tag);
        int lead = 0, high = 0, rises = 0, trail = 0;
        logic prev;
        entry_pre_sel_i = ps; pre_dly_i = pd; entry_post_sel_i = qs;
        post_dly_i = qd; half_period_i = h;
        entry_valid_i = 1;
        #1;
        chk("R7 take before cs", entry_take_o == 1'b1 && cs_n_o == 1'b1, entry_take_o, 1);
        @(negedge clk);
        entry_valid_i = 0;
        chk("R7 cs falls after take", cs_n_o == 1'b0, cs_n_o, 0);
        while (cs_n_o == 1'b0 && sck_o == 1'b0) begin
            lead++;
            @(negedge clk);
        end
        chk(lead_tag, lead == exp_lead, lead, exp_lead);
        prev = 1'b0;
        while (cs_n_o == 1'b0) begin
            if (sck_o) high++;
            if (sck_o && !prev) rises++;
            prev = sck_o;
            @(negedge clk);
        end
        chk("R4 sck pulses", rises == 8, rises, 8);
        chk("R4 sck high time", high == exp_high, high, exp_high);
        chk("R4 sck low at cs rise", sck_o == 1'b0, sck_o, 0);
        while (busy_o == 1'b1 && cs_n_o == 1'b1) begin
            trail++;
            @(negedge clk);
        end
        chk(trail_tag, trail == exp_trail, trail, exp_trail);
    endtask

    task automatic t_reset();
        chk("R11 cs_n", cs_n_o == 1'b1, cs_n_o, 1);
        chk("R11 quiet outputs",
            {sck_o, busy_o, halt_ack_o, spe_o, modf_o, entry_take_o} == 6'b0,
            {sck_o, busy_o, halt_ack_o, spe_o, modf_o, entry_take_o}, 0);
    endtask

    task automatic t_delays();
        run_xfer(1, 7'd5,   0, 8'd9, 8'd2, 5,   16, 17,   "R1 lead 5",   "R6 std trail");
        run_xfer(1, 7'd127, 1, 8'd3, 8'd1, 127, 8,  96,   "R1 lead 127", "R5 trail 3*32");
        run_xfer(1, 7'd0,   1, 8'd1, 8'd1, 128, 8,  32,   "R2 lead zero", "R5 trail 32");
        run_xfer(1, 7'd1,   1, 8'd0, 8'd1, 2,   8,  8192, "R2 lead one",  "R5 trail zero");
        run_xfer(0, 7'd50,  0, 8'd0, 8'd3, 3,   24, 17,   "R3 half lead", "R6 trail ignores field");
        run_xfer(0, 7'd9,   0, 8'd5, 8'd0, 1,   8,  17,   "R3 half zero", "R6 std trail again");
    endtask

    task automatic t_halt();
        int low_seen = 0;
        entry_pre_sel_i = 1; pre_dly_i = 7'd4; entry_post_sel_i = 0; half_period_i = 8'd1;
        entry_valid_i = 1;
        @(negedge clk);
        halt_req_i = 1;
        while (busy_o) @(negedge clk);
        chk("R8 ack after trail", halt_ack_o == 1'b1, halt_ack_o, 1);
        repeat (20) begin
            @(negedge clk);
            if (!cs_n_o || entry_take_o) low_seen++;
        end
        chk("R8 no start while halted", low_seen == 0, low_seen, 0);
        halt_req_i = 0;
        @(negedge clk);
        chk("R8 ack drops", halt_ack_o == 1'b0 && cs_n_o == 1'b1, halt_ack_o, 0);
        @(negedge clk);
        chk("R8 resumes", cs_n_o == 1'b0, cs_n_o, 0);
        entry_valid_i = 0;
        while (busy_o) @(negedge clk);
    endtask

    task automatic t_spe_clear();
        int low_seen = 0;
        entry_pre_sel_i = 1; pre_dly_i = 7'd3; half_period_i = 8'd4;
        entry_valid_i = 1;
        @(negedge clk);
        entry_valid_i = 0;
        while (!sck_o) @(negedge clk);
        spe_clr_i = 1;
        @(negedge clk);
        spe_clr_i = 0;
        chk("R9 stop mid shift", {spe_o, cs_n_o, sck_o, busy_o} == 4'b0100,
            {spe_o, cs_n_o, sck_o, busy_o}, 4'b0100);
        entry_valid_i = 1;
        repeat (10) begin
            #1;
            if (!cs_n_o || entry_take_o) low_seen++;
            @(negedge clk);
        end
        entry_valid_i = 0;
        chk("R9 no take disabled", low_seen == 0, low_seen, 0);
        pulse_set();
        chk("R9 re-enabled", spe_o == 1'b1, spe_o, 1);
    endtask

    task automatic t_modf();
        ss_is_input_i = 1; master_i = 0; ss_n_i = 0;
        @(negedge clk);
        chk("R10 no fault as slave", spe_o == 1'b1 && modf_o == 1'b0, modf_o, 0);
        ss_is_input_i = 0; master_i = 1;
        @(negedge clk);
        chk("R10 no fault pin output", spe_o == 1'b1 && modf_o == 1'b0, modf_o, 0);
        ss_is_input_i = 1;
        @(negedge clk);
        chk("R10 fault clears spe", spe_o == 1'b0, spe_o, 0);
        chk("R10 fault flag", modf_o == 1'b1, modf_o, 1);
        ss_n_i = 1;
        pulse_set();
        chk("R10 flag sticky", spe_o == 1'b1 && modf_o == 1'b1, modf_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        pulse_set();
        t_delays();
        t_halt();
        t_spe_clear();
        t_modf();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule